// File: doc/BRIEF.md
# Receive Frame Length Classifier

This block watches a receive byte stream, one byte per beat, marked with start-of-frame and end-of-frame. Preamble and start delimiter have already been removed. For every frame it reports, on the beat that carries the last byte, whether the frame was undersized and in which of two classes, whether it was a MAC control frame, whether that control frame was a pause frame, and whether the frame is being dropped. A programmable threshold of up to 31 bytes divides undersized frames into the very small "short" class and the "runt" class below the 64-byte minimum.

The block also produces a filtered copy of the stream. Every beat leaves exactly 16 cycles after it entered. That delay is long enough for the type field and the opcode to be decoded before the first byte of a frame leaves. When dropping is enabled, control frames other than pause frames are removed whole, and every other frame passes through unchanged. Two write-only settings are reached through a small configuration port.

Top module: `rx_len_classifier`

## Requirements
- R1: After reset the undersize threshold is 8. A write with `cfg_addr`=0 loads `cfg_wdata[4:0]` as the new threshold, which applies from the next cycle.
- R2: Frame length is the number of valid beats from the start-of-frame beat to the end-of-frame beat, inclusive. A frame of a single beat has length 1.
- R3: `flag_short` is raised for a frame whose length is less than the threshold.
- R4: `flag_runt` is raised for a frame whose length is at least the threshold and less than 64. The two undersize flags are never raised together, and with a threshold of 0 no frame is short.
- R5: A frame of 64 bytes or more raises neither undersize flag. The internal length count saturates at 255 instead of wrapping, so a 300-byte frame is still treated as long.
- R6: `flag_ctrl` is raised when the frame has at least 14 bytes and byte 12 is 0x88 and byte 13 is 0x08, counting from byte 0.
- R7: `flag_pause` is raised when the frame is a control frame, has at least 16 bytes, and byte 14 is 0x00 and byte 15 is 0x01. A pause frame always also raises `flag_ctrl`.
- R8: The drop enable resets to 0. A write with `cfg_addr`=1 loads it from `cfg_wdata[0]`. `flag_discard` is raised when the frame is a control frame, is not a pause frame, and the enable is 1.
- R9: All five flags are combinational, high only during the single cycle in which the end-of-frame beat is present on the input, and low in every other cycle.
- R10: Each beat of a frame that is not discarded appears on the output 16 cycles after it was presented, with identical data, start and end markers. A discarded frame produces no output beat, and `out_valid` is low in every cycle that carries no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects the threshold, 1 selects the drop enable |
| cfg_wdata | input | 5 | Configuration write data |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_data | input | 8 | Input byte |
| flag_short | output | 1 | Frame shorter than threshold |
| flag_runt | output | 1 | Frame between threshold and 63 bytes |
| flag_ctrl | output | 1 | MAC control frame |
| flag_pause | output | 1 | Pause control frame |
| flag_discard | output | 1 | Frame is removed from the output stream |
| out_valid | output | 1 | Output beat valid |
| out_sof | output | 1 | Output first byte of frame |
| out_eof | output | 1 | Output last byte of frame |
| out_data | output | 8 | Output byte |

## Verification
The assertions assume that the beats of a frame arrive on consecutive cycles with no idle gap, and that every end-of-frame beat is followed either by an idle cycle or by a new start-of-frame beat. The drop-decision queue stays within its depth only under that assumption. The stimulus holds `in_valid` high from the first byte to the last byte of every frame, and places any gap only between frames, often with no gap at all. Configuration writes are issued only while the input is idle, so that a frame never sees a setting change partway through.

// File: rtl/rxlc_pkg.sv
package rxlc_pkg;

  localparam int BYTE_W      = 8;
  // byte positions in the frame, counted from 0 after the start delimiter
  localparam int TYPE_HI_IDX = 12;
  localparam int TYPE_LO_IDX = 13;
  localparam int OPC_HI_IDX  = 14;
  localparam int OPC_LO_IDX  = 15;
  // last byte that the forwarding decision depends on
  localparam int DEC_IDX     = OPC_LO_IDX;

  localparam logic [15:0] CTRL_ETYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPC  = 16'h0001;

  typedef struct packed {
    logic              vld;
    logic              sof;
    logic              eof;
    logic [BYTE_W-1:0] data;
  } rxlc_beat_t;

endpackage

// File: rtl/rxlc_cfg_regs.sv
module rxlc_cfg_regs #(
  parameter int THR_W   = 5,
  parameter int THR_RST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [THR_W-1:0] cfg_wdata,
  output logic [THR_W-1:0] thr_o,
  output logic             drop_en_o
);

  logic [THR_W-1:0] thr_q, thr_d;
  logic             en_q, en_d;
  logic             thr_we, en_we;

  assign thr_we = cfg_wr && !cfg_addr;
  assign en_we  = cfg_wr &&  cfg_addr;

  always_comb begin
    thr_d = thr_q;
    en_d  = en_q;
    if (thr_we) thr_d = cfg_wdata;
    if (en_we)  en_d  = cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_W'(THR_RST);
      en_q  <= 1'b0;
    end else begin
      thr_q <= thr_d;
      en_q  <= en_d;
    end
  end

  assign thr_o     = thr_q;
  assign drop_en_o = en_q;

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !cfg_wr |=> ($stable(thr_q) && $stable(en_q))); // R1

endmodule

// File: rtl/rxlc_frame_track.sv
module rxlc_frame_track
  import rxlc_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int THR_W   = 5,
  parameter int MIN_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [THR_W-1:0]  thr,
  input  logic              drop_en,
  output logic              flg_short,
  output logic              flg_runt,
  output logic              flg_ctrl,
  output logic              flg_pause,
  output logic              flg_discard,
  output logic              dec_push,
  output logic              dec_drop
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] I_THI   = LEN_W'(TYPE_HI_IDX);
  localparam logic [LEN_W-1:0] I_TLO   = LEN_W'(TYPE_LO_IDX);
  localparam logic [LEN_W-1:0] I_OHI   = LEN_W'(OPC_HI_IDX);
  localparam logic [LEN_W-1:0] I_OLO   = LEN_W'(OPC_LO_IDX);
  localparam logic [LEN_W-1:0] I_DEC   = LEN_W'(DEC_IDX);

  logic [LEN_W-1:0] cnt_q, cnt_d, idx, len_now, thr_ext;
  logic             thi_q, thi_d, ohi_q, ohi_d;
  logic             ctrl_q, ctrl_d, pause_q, pause_d;
  logic             ctrl_now, pause_now, eof_beat, flg_any;

  assign thr_ext  = LEN_W'(thr);
  assign eof_beat = in_valid && in_eof;

  // per-beat view: position of the present byte and length including it
  always_comb begin
    idx     = in_sof ? '0 : cnt_q;
    len_now = (idx == LEN_MAX) ? LEN_MAX : idx + 1'b1;

    ctrl_now = 1'b0;
    if (idx == I_TLO)     ctrl_now = thi_q && (in_data == CTRL_ETYPE[7:0]);
    else if (idx > I_TLO) ctrl_now = ctrl_q;

    pause_now = 1'b0;
    if (idx == I_OLO)     pause_now = ctrl_q && ohi_q && (in_data == PAUSE_OPC[7:0]);
    else if (idx > I_OLO) pause_now = pause_q;
  end

  // next-state
  always_comb begin
    cnt_d   = cnt_q;
    thi_d   = thi_q;
    ohi_d   = ohi_q;
    ctrl_d  = ctrl_q;
    pause_d = pause_q;
    if (in_valid) begin
      cnt_d   = len_now;
      ctrl_d  = ctrl_now;
      pause_d = pause_now;
      if (idx == I_THI) thi_d = (in_data == CTRL_ETYPE[15:8]);
      if (idx == I_OHI) ohi_d = (in_data == PAUSE_OPC[15:8]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      thi_q   <= 1'b0;
      ohi_q   <= 1'b0;
      ctrl_q  <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      thi_q   <= thi_d;
      ohi_q   <= ohi_d;
      ctrl_q  <= ctrl_d;
      pause_q <= pause_d;
    end
  end

  // classification on the end-of-frame beat
  assign flg_short   = eof_beat && (len_now < thr_ext);
  assign flg_runt    = eof_beat && (len_now >= thr_ext) && (len_now < MIN_L);
  assign flg_ctrl    = eof_beat && ctrl_now;
  assign flg_pause   = eof_beat && pause_now;
  assign flg_discard = eof_beat && ctrl_now && !pause_now && drop_en;
  assign flg_any     = flg_short | flg_runt | flg_ctrl | flg_pause | flg_discard;

  // forwarding decision: once the opcode is complete, or at an earlier end
  assign dec_push = in_valid && ((idx == I_DEC) || (in_eof && (idx < I_DEC)));
  assign dec_drop = ctrl_now && !pause_now && drop_en;

  AST_INPUT_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_eof) |=> in_valid); // R2
  AST_UNDERSIZE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(flg_short && flg_runt)); // R4
  AST_FLAGS_ON_EOF: assert property (@(posedge clk) disable iff (!rst_n) flg_any |-> (in_valid && in_eof)); // R9
  AST_PAUSE_IS_CTRL: assert property (@(posedge clk) disable iff (!rst_n) flg_pause |-> flg_ctrl); // R7
  AST_LEN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_sof && (cnt_q == LEN_MAX)) |=> (cnt_q == LEN_MAX)); // R5
  AST_LONG_NOT_UNDERSIZE: assert property (@(posedge clk) disable iff (!rst_n) (eof_beat && !in_sof && (cnt_q >= MIN_L)) |-> (!flg_short && !flg_runt)); // R5

endmodule

// File: rtl/rxlc_delay_line.sv
module rxlc_delay_line
  import rxlc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  rxlc_beat_t beat_i,
  output rxlc_beat_t beat_o
);

  localparam int W = $bits(rxlc_beat_t);

  logic [DEPTH-1:0][W-1:0] stage_q, stage_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb stage_d = beat_i;
    end else begin : g_chain
      always_comb stage_d = {stage_q[DEPTH-2:0], beat_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign beat_o = stage_q[DEPTH-1];

endmodule

// File: rtl/rxlc_drop_gate.sv
module rxlc_drop_gate
  import rxlc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_push,
  input  logic              dec_drop,
  input  rxlc_beat_t        tail_i,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [BYTE_W-1:0] out_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DEPTH-1:0] fifo_q, fifo_d;
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             hold_q, hold_d;
  logic             pop, drop_now;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign pop      = tail_i.vld && tail_i.sof;
  assign drop_now = pop ? fifo_q[rd_q] : hold_q;

  always_comb begin
    fifo_d = fifo_q;
    wr_d   = wr_q;
    rd_d   = rd_q;
    hold_d = hold_q;
    if (dec_push) begin
      fifo_d[wr_q] = dec_drop;
      wr_d         = adv(wr_q);
    end
    if (pop) begin
      rd_d   = adv(rd_q);
      hold_d = drop_now;
    end
    cnt_d = cnt_q + CW'(dec_push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_q <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      fifo_q <= fifo_d;
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign out_valid = tail_i.vld && !drop_now;
  assign out_sof   = out_valid && tail_i.sof;
  assign out_eof   = out_valid && tail_i.eof;
  assign out_data  = out_valid ? tail_i.data : '0;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (dec_push && !pop) |-> (cnt_q != FULL)); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> (cnt_q != '0)); // R10
  AST_WHOLE_FRAME_OUT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_eof) |=> out_valid); // R10

endmodule

// File: rtl/rx_len_classifier.sv
module rx_len_classifier
  import rxlc_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int THR_W   = 5,
  parameter int THR_RST = 8,
  parameter int MIN_LEN = 64,
  parameter int DELAY   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_addr,
  input  logic [THR_W-1:0] cfg_wdata,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  output logic             flag_short,
  output logic             flag_runt,
  output logic             flag_ctrl,
  output logic             flag_pause,
  output logic             flag_discard,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eof,
  output logic [7:0]       out_data
);

  generate
    if (DELAY <= DEC_IDX) begin : g_bad_delay
      $error("DELAY must exceed the last decoded byte position");
    end
  endgenerate

  // reset: asserted at once, removed on a clock edge
  logic [1:0] rs_q, rs_d;
  logic       rst_sync_n;

  always_comb rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_sync_n = rs_q[1];

  logic [THR_W-1:0] thr;
  logic             drop_en, dec_push, dec_drop;
  rxlc_beat_t       head, tail;

  rxlc_cfg_regs #(.THR_W(THR_W), .THR_RST(THR_RST)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .thr_o     (thr),
    .drop_en_o (drop_en)
  );

  rxlc_frame_track #(.LEN_W(LEN_W), .THR_W(THR_W), .MIN_LEN(MIN_LEN)) u_track (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .in_data     (in_data),
    .thr         (thr),
    .drop_en     (drop_en),
    .flg_short   (flag_short),
    .flg_runt    (flag_runt),
    .flg_ctrl    (flag_ctrl),
    .flg_pause   (flag_pause),
    .flg_discard (flag_discard),
    .dec_push    (dec_push),
    .dec_drop    (dec_drop)
  );

  always_comb begin
    head.vld  = in_valid;
    head.sof  = in_valid && in_sof;
    head.eof  = in_valid && in_eof;
    head.data = in_data;
  end

  rxlc_delay_line #(.DEPTH(DELAY)) u_delay (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .beat_i (head),
    .beat_o (tail)
  );

  rxlc_drop_gate #(.DEPTH(DELAY)) u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .dec_push  (dec_push),
    .dec_drop  (dec_drop),
    .tail_i    (tail),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_data  (out_data)
  );

endmodule

// File: tb/rx_len_classifier_test.sv
`timescale 1ns/1ps
module rx_len_classifier_test;

  typedef struct {
    bit       v;
    bit       sof;
    bit       eof;
    bit [7:0] data;
    bit       drop;
  } ent_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_addr = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic       flag_short, flag_runt, flag_ctrl, flag_pause, flag_discard;
  logic       out_valid, out_sof, out_eof;
  logic [7:0] out_data;

  int   n_cmp = 0, n_bad = 0;
  int   thr = 8;
  bit   drop_en = 1'b0;
  bit   mon_on = 1'b0, done = 1'b0;
  bit   e_short = 0, e_runt = 0, e_ctrl = 0, e_pause = 0, e_disc = 0, cur_drop = 0;
  string cur_tag = "idle";
  logic [7:0] fbuf [0:511];
  ent_t q[$];

  always #4 clk = ~clk;

  rx_len_classifier uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .flag_short(flag_short), .flag_runt(flag_runt), .flag_ctrl(flag_ctrl),
    .flag_pause(flag_pause), .flag_discard(flag_discard),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // reference model, compared every cycle away from the clock edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(out_valid === 1'b0, "R1 reset out_valid", int'(out_valid), 0);
      chk({flag_short, flag_runt, flag_ctrl, flag_pause, flag_discard} === 5'b0, "R1 reset flags",
          int'({flag_short, flag_runt, flag_ctrl, flag_pause, flag_discard}), 0);
    end else if (mon_on) begin
      ent_t e, o;
      string sfx;
      sfx = (in_valid && in_eof) ? cur_tag : {cur_tag, " R9 non-eof cycle"};
      chk(flag_short   === e_short, {"R3 flag_short ", sfx},   int'(flag_short),   int'(e_short));
      chk(flag_runt    === e_runt,  {"R4 flag_runt ", sfx},    int'(flag_runt),    int'(e_runt));
      chk(flag_ctrl    === e_ctrl,  {"R6 flag_ctrl ", sfx},    int'(flag_ctrl),    int'(e_ctrl));
      chk(flag_pause   === e_pause, {"R7 flag_pause ", sfx},   int'(flag_pause),   int'(e_pause));
      chk(flag_discard === e_disc,  {"R8 flag_discard ", sfx}, int'(flag_discard), int'(e_disc));
      e.v = in_valid; e.sof = in_sof; e.eof = in_eof; e.data = in_data; e.drop = cur_drop;
      q.push_back(e);
      o = q.pop_front();
      chk(out_valid === (o.v && !o.drop), "R10 out_valid", int'(out_valid), int'(o.v && !o.drop));
      if (o.v && !o.drop) begin
        chk({out_sof, out_eof, out_data} === {o.sof, o.eof, o.data}, "R10 out beat",
            int'({out_sof, out_eof, out_data}), int'({o.sof, o.eof, o.data}));
      end
    end
  end

  task automatic idle();
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = '0;
    e_short = 0; e_runt = 0; e_ctrl = 0; e_pause = 0; e_disc = 0;
  endtask

  task automatic wr_cfg(input bit a, input int v);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_addr = a; cfg_wdata = 5'(v);
    @(posedge clk); #1;
    cfg_wr = 0;
    if (!a) thr = v; else drop_en = v[0];
  endtask

  // kind: 0 plain, 1 unknown control, 2 pause
  task automatic send(input int len, input int kind, input int gap, input string tag);
    bit sh, ru, ct, pa, di;
    for (int i = 0; i < len; i++) fbuf[i] = 8'((i * 13 + len) & 255);
    if (kind == 0) begin
      if (len > 12) fbuf[12] = 8'h08;
      if (len > 13) fbuf[13] = 8'h00;
    end else begin
      if (len > 12) fbuf[12] = 8'h88;
      if (len > 13) fbuf[13] = 8'h08;
      if (len > 14) fbuf[14] = 8'h00;
      if (len > 15) fbuf[15] = (kind == 2) ? 8'h01 : 8'h02;
    end
    sh = len < thr;
    ru = (len >= thr) && (len < 64);
    ct = (len >= 14) && fbuf[12] == 8'h88 && fbuf[13] == 8'h08;
    pa = ct && (len >= 16) && fbuf[14] == 8'h00 && fbuf[15] == 8'h01;
    di = ct && !pa && drop_en;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      cur_tag = tag; cur_drop = di;
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1); in_data = fbuf[i];
      if (i == len - 1) begin
        e_short = sh; e_runt = ru; e_ctrl = ct; e_pause = pa; e_disc = di;
      end else begin
        e_short = 0; e_runt = 0; e_ctrl = 0; e_pause = 0; e_disc = 0;
      end
    end
    if (gap > 0) begin
      @(posedge clk); #1;
      idle();
      repeat (gap - 1) @(posedge clk);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    for (int i = 0; i < 16; i++) begin
      ent_t z;
      z.v = 0; z.sof = 0; z.eof = 0; z.data = 0; z.drop = 0;
      q.push_back(z);
    end
    mon_on = 1;
    repeat (3) @(posedge clk);
    // default threshold of 8
    send(7, 0, 2, "R1 default thr short");
    send(8, 0, 2, "R1 default thr runt");
    send(1, 0, 1, "R2 single beat");
    send(63, 0, 2, "R4 length 63");
    send(64, 0, 2, "R5 length 64");
    // programmed thresholds
    wr_cfg(0, 20);
    send(19, 0, 1, "R3 below 20");
    send(20, 0, 1, "R4 at 20");
    send(5, 0, 1, "R3 length 5");
    wr_cfg(0, 0);
    send(1, 0, 1, "R4 thr 0");
    wr_cfg(0, 31);
    send(30, 0, 1, "R3 below 31");
    send(31, 0, 1, "R4 at 31");
    send(300, 0, 2, "R5 saturation");
    wr_cfg(0, 8);
    // control frames, forwarding
    send(64, 1, 2, "R6 unknown ctrl kept");
    send(64, 2, 2, "R7 pause");
    send(13, 1, 2, "R6 type incomplete");
    // control frames, dropping
    wr_cfg(1, 1);
    send(60, 1, 2, "R8 unknown ctrl dropped");
    send(64, 2, 2, "R8 pause kept");
    send(14, 1, 2, "R8 ctrl 14 dropped");
    send(15, 2, 2, "R7 opcode incomplete");
    send(40, 0, 2, "R10 plain");
    // back to back
    for (int k = 0; k < 6; k++) begin
      send(14, 1, 0, "R10 b2b ctrl");
      send(1, 0, 0, "R10 b2b tiny");
      send(16, 2, 0, "R10 b2b pause");
      send(17, 1, 0, "R10 b2b ctrl17");
    end
    send(2, 0, 1, "R10 tail");
    wr_cfg(1, 0);
    send(16, 1, 0, "R8 disabled");
    send(20, 1, 1, "R8 disabled 2");
    repeat (24) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule